// File: doc/BRIEF.md
# Decimator Clock and Control Sequencer

This block sits next to a decimation filter and runs from the master input clock. It divides that clock by four to make the modulator clock, and it produces a filter enable and a one-cycle filter clear pulse. It also gates the filter when power-down is requested, keeps the filter idle after wake-up until a fresh sync arrives, and picks the filter input bit from either the modulator bitstream or a test bitstream.

Sync acts on its rising edge only. A sync that lands exactly on the last master cycle of a decimation period leaves the filter alone, because the period restarts on that edge anyway. It still re-arms the filter after power-down. A modulator overrange flag is sampled on every rising master edge. Once the flag is seen, a sticky error status is set and an active-low error output is driven. Both stay until the block reset.

Top module: `dcs_top`

## Requirements
- R1: While the synchronous active-low reset is applied, the modulator clock is low, the filter enable is high, the filter clear is low, the active-low error output is high and the error status is low.
- R2: While not powered down, the modulator clock has a period of exactly four master cycles, with two cycles high and two cycles low.
- R3: Power-down takes effect on the first falling master edge after the power-down input goes high. The filter enable drops at that falling edge, not before it. The modulator clock then holds its level for as long as power-down lasts.
- R4: After power-down ends, the filter enable stays low until a sync rising edge is seen. A sync pulse that arrives during power-down produces no clear and does not re-arm the filter.
- R5: A sync rising edge seen at a rising master edge makes the filter clear high for the single following cycle. Holding sync high produces no further clear.
- R6: A sync rising edge restarts the clock divider. Sampled after the sync edge and then after each of the next four edges, the modulator clock reads 0, 0, 1, 1, 0.
- R7: A decimation period lasts 4*DECIM_MCLKS master cycles, counted from the last divider restart or decimator reset. A sync rising edge on the last cycle of a period produces no clear, but it still raises the filter enable.
- R8: While the decimator reset input is high at a rising edge, the filter clear is high in the following cycle. It falls one edge after the input is released.
- R9: The overrange input is sampled only on rising master edges. After an edge where it is high, the error status is 1 and the active-low error output is 0.
- R10: The error status and the error output stay asserted after overrange clears, until the block reset.
- R11: The filter data output equals the test bit when the input select is 1 and the modulator bit when the select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| pwrdn_i | input | 1 | Power-down request, acted on at the falling edge |
| sync_i | input | 1 | Filter sync, acts on its rising edge |
| dec_rst_i | input | 1 | Decimator reset, level sensitive |
| ovr_i | input | 1 | Modulator overrange flag |
| sel_test_i | input | 1 | Filter input select: 1 = test bit, 0 = modulator bit |
| mdat_i | input | 1 | Modulator bitstream |
| tdat_i | input | 1 | Test bitstream |
| mclk_o | output | 1 | Modulator clock, master divided by four |
| filt_en_o | output | 1 | Filter convolution enable |
| filt_clr_o | output | 1 | Filter clear pulse |
| filt_din_o | output | 1 | Selected filter input bit |
| err_n_o | output | 1 | Active-low error indication |
| err_stat_o | output | 1 | Sticky error status bit |

## Verification
Sync is exercised with three patterns, each of which gives a different expected clear and enable:
- a one-cycle pulse in the middle of a period;
- a level held high, which must give only one clear;
- a pulse placed on the last cycle of a decimation period, which must give no clear but a restored enable.

The divider phase is read after a sync to separate a true restart from a free-running count. Power-down is probed both before and after the falling edge to pin down the edge it acts on. A sync pulse inside power-down shows whether that sync is really ignored. Overrange is driven and then checked both before and after the rising edge, so sampling on the clock edge can be told apart from a combinational path.

// File: rtl/dcs_pkg.sv
// Package: shared types for the decimator clock and control sequencer.
// Assumes: single master clock domain, no other users of these types.
package dcs_pkg;

    // Filter input source selection
    typedef enum logic {
        SRC_MODULATOR = 1'b0,
        SRC_TEST      = 1'b1
    } src_sel_e;

    // Width helper for counters sized from a count
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dcs_mclk_div.sv
// Module: modulator clock divider.
// Does:    counts master cycles modulo DIV, drives the upper half of the
//          count as the modulator clock (50% duty for even DIV).
// Assumes: hold and restart come from the same master clock domain; hold
//          wins over restart.
module dcs_mclk_div #(
    parameter int unsigned DIV = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic hold_i,
    input  logic restart_i,
    output logic mclk_o
);
    localparam int unsigned CW   = dcs_pkg::cnt_width(DIV);
    localparam int unsigned HALF = DIV / 2;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Divider counter: freeze on hold, zero on restart, else wrap at DIV
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else if (hold_i) begin
            cnt_q <= cnt_q;
        end else if (restart_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Modulator clock is high during the upper half of the count
    assign mclk_o = (cnt_q >= CW'(HALF));

    // R3: count stays frozen while held
    p_div_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        hold_i |=> $stable(cnt_q));

    // R6: restart brings the count to zero
    p_div_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (restart_i && !hold_i) |=> (cnt_q == '0));

endmodule

// File: rtl/dcs_conv_seq.sv
// Module: convolution sequencer.
// Does:    detects sync rising edges, tracks the decimation period, issues
//          the filter clear pulse and keeps the arm flag that gates the
//          filter enable across power-down.
// Assumes: pd_i is already aligned to the falling-edge rule by the parent;
//          a decimation period is PERIOD master cycles.
module dcs_conv_seq #(
    parameter int unsigned PERIOD = 32
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pd_i,
    input  logic sync_i,
    input  logic dec_rst_i,
    output logic restart_o,
    output logic armed_o,
    output logic clr_o
);
    localparam int unsigned DW = dcs_pkg::cnt_width(PERIOD);
    localparam logic [DW-1:0] LAST = DW'(PERIOD - 1);

    logic          sync_q;
    logic [DW-1:0] dec_q;
    logic          armed_q;
    logic          clr_q;
    logic          rise;
    logic          at_last;

    assign rise    = sync_i & ~sync_q;
    assign at_last = (dec_q == LAST);

    // Sync history for edge detection (tracks even during power-down)
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) sync_q <= 1'b0;
        else          sync_q <= sync_i;
    end

    // Decimation phase counter: frozen in power-down, zeroed on sync or reset
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            dec_q <= '0;
        end else if (dec_rst_i) begin
            dec_q <= '0;
        end else if (pd_i) begin
            dec_q <= dec_q;
        end else if (rise || at_last) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_q + 1'b1;
        end
    end

    // Arm flag: dropped in power-down, raised again by a sync edge
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)        armed_q <= 1'b1;
        else if (pd_i)       armed_q <= 1'b0;
        else if (rise)       armed_q <= 1'b1;
    end

    // Clear pulse: decimator reset level, or off-boundary sync edge
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) clr_q <= 1'b0;
        else          clr_q <= dec_rst_i | (rise & ~pd_i & ~at_last);
    end

    assign restart_o = rise & ~pd_i;
    assign armed_o   = armed_q;
    assign clr_o     = clr_q;

    // R5: a held sync level gives no further clear
    p_clr_single_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (sync_i && sync_q && !dec_rst_i) |=> !clr_q);

    // R4: power-down disarms the filter
    p_pd_disarm_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pd_i |=> !armed_q);

    // R8: decimator reset always yields a clear next cycle
    p_decrst_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        dec_rst_i |=> clr_q);

endmodule

// File: rtl/dcs_err_latch.sv
// Module: overrange error latch.
// Does:    samples the overrange flag on rising edges into a sticky status.
// Assumes: only the block reset clears the status.
module dcs_err_latch (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic ovr_i,
    output logic err_stat_o,
    output logic err_n_o
);
    logic stat_q;

    // Sticky status: set by a sampled overrange, held until reset
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)   stat_q <= 1'b0;
        else if (ovr_i) stat_q <= 1'b1;
    end

    assign err_stat_o = stat_q;
    assign err_n_o    = ~stat_q;

    // R9: a sampled overrange sets the status
    p_ovr_set_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ovr_i |=> stat_q);

    // R10: status never self-clears
    p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        stat_q |=> stat_q);

endmodule

// File: rtl/dcs_top.sv
// Module: decimator clock and control sequencer, top level.
// Does:    aligns power-down to the falling master edge, combines divider,
//          sequencer and error latch, and selects the filter input bit.
// Assumes: all inputs are synchronous to clk_i; reset is synchronous.
module dcs_top #(
    parameter int unsigned MCLK_DIV    = 4,
    parameter int unsigned DECIM_MCLKS = 8
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pwrdn_i,
    input  logic sync_i,
    input  logic dec_rst_i,
    input  logic ovr_i,
    input  logic sel_test_i,
    input  logic mdat_i,
    input  logic tdat_i,
    output logic mclk_o,
    output logic filt_en_o,
    output logic filt_clr_o,
    output logic filt_din_o,
    output logic err_n_o,
    output logic err_stat_o
);
    import dcs_pkg::*;

    localparam int unsigned PERIOD = MCLK_DIV * DECIM_MCLKS;

    logic     pd_q;
    logic     restart;
    logic     armed;
    src_sel_e src;

    // Power-down capture on the falling master edge
    always_ff @(negedge clk_i) begin
        if (!rst_n_i) pd_q <= 1'b0;
        else          pd_q <= pwrdn_i;
    end

    dcs_mclk_div #(.DIV(MCLK_DIV)) u_div (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .hold_i    (pd_q),
        .restart_i (restart),
        .mclk_o    (mclk_o)
    );

    dcs_conv_seq #(.PERIOD(PERIOD)) u_seq (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .pd_i      (pd_q),
        .sync_i    (sync_i),
        .dec_rst_i (dec_rst_i),
        .restart_o (restart),
        .armed_o   (armed),
        .clr_o     (filt_clr_o)
    );

    dcs_err_latch u_err (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .ovr_i      (ovr_i),
        .err_stat_o (err_stat_o),
        .err_n_o    (err_n_o)
    );

    // Filter input source mux
    assign src        = src_sel_e'(sel_test_i);
    assign filt_din_o = (src == SRC_TEST) ? tdat_i : mdat_i;
    assign filt_en_o  = armed & ~pd_q;

    // R3: enable is low whenever power-down is in force at a rising edge
    p_no_en_pd_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pd_q |-> !filt_en_o);

endmodule

// File: tb/dcs_top_tb_top.sv
// Directed bench for the decimator clock and control sequencer.
module dcs_top_tb_top;

    logic clk = 1'b0;
    logic rst_n, pwrdn, sync, dec_rst, ovr, sel_test, mdat, tdat;
    logic mclk, filt_en, filt_clr, filt_din, err_n, err_stat;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dcs_top #(.MCLK_DIV(4), .DECIM_MCLKS(8)) dut_i (
        .clk_i      (clk),
        .rst_n_i    (rst_n),
        .pwrdn_i    (pwrdn),
        .sync_i     (sync),
        .dec_rst_i  (dec_rst),
        .ovr_i      (ovr),
        .sel_test_i (sel_test),
        .mdat_i     (mdat),
        .tdat_i     (tdat),
        .mclk_o     (mclk),
        .filt_en_o  (filt_en),
        .filt_clr_o (filt_clr),
        .filt_din_o (filt_din),
        .err_n_o    (err_n),
        .err_stat_o (err_stat)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to 1 ns after the next rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Zero the decimation phase, then step one cycle so phase is 1
    task automatic phase_to_one();
        dec_rst = 1'b1; tick();
        dec_rst = 1'b0; tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1 mclk", mclk, 0);
        chk("R1 enable", filt_en, 1);
        chk("R1 clear", filt_clr, 0);
        chk("R1 err_n", err_n, 1);
        chk("R1 status", err_stat, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_divide();
        int rises = 0;
        int highs = 0;
        logic prev;
        tick();
        prev = mclk;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (mclk && !prev) rises++;
            if (mclk) highs++;
            prev = mclk;
        end
        chk("R2 rising edges in 40 cycles", rises, 10);
        chk("R2 high cycles in 40 cycles", highs, 20);
    endtask

    task automatic t_sync_mid();
        int extra = 0;
        int exp_ph[5] = '{0, 0, 1, 1, 0};
        phase_to_one();
        sync = 1'b1; tick();
        chk("R5 clear after sync edge", filt_clr, 1);
        chk("R6 mclk phase 0", mclk, exp_ph[0]);
        for (int i = 1; i < 5; i++) begin
            tick();
            chk("R6 mclk phase", mclk, exp_ph[i]);
            if (filt_clr) extra++;
        end
        for (int i = 0; i < 4; i++) begin
            tick();
            if (filt_clr) extra++;
        end
        chk("R5 no clear while sync held", extra, 0);
        sync = 1'b0; tick();
    endtask

    task automatic t_pwrdn_boundary();
        int same = 1;
        int moves = 0;
        int en_seen = 0;
        logic m0;
        logic prev;
        phase_to_one();
        sync = 1'b1; tick();        // sync edge, phase restarts at 0
        sync = 1'b0;
        pwrdn = 1'b1;
        #1;
        chk("R3 enable before falling edge", filt_en, 1);
        @(negedge clk); #1;
        chk("R3 enable after falling edge", filt_en, 0);
        m0 = mclk;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (mclk != m0) same = 0;
        end
        chk("R3 mclk frozen", same, 1);
        sync = 1'b1; tick();
        chk("R4 no clear from sync in power-down", filt_clr, 0);
        sync = 1'b0; tick();
        pwrdn = 1'b0;               // phase resumes from 0 at next edge
        prev = mclk;
        for (int i = 0; i < 31; i++) begin
            tick();
            if (filt_en) en_seen++;
            if (mclk != prev) moves++;
            prev = mclk;
        end
        chk("R4 enable stays low without sync", en_seen, 0);
        chk("R2 mclk runs after wake-up", (moves > 0) ? 1 : 0, 1);
        sync = 1'b1; tick();        // lands on last cycle of period
        chk("R7 no clear on boundary sync", filt_clr, 0);
        chk("R7 boundary sync re-arms enable", filt_en, 1);
        sync = 1'b0; tick();
    endtask

    task automatic t_decrst();
        dec_rst = 1'b1; tick();
        chk("R8 clear while reset high", filt_clr, 1);
        tick();
        chk("R8 clear held", filt_clr, 1);
        dec_rst = 1'b0; tick();
        chk("R8 clear released", filt_clr, 0);
    endtask

    task automatic t_error();
        int drops = 0;
        chk("R9 status before overrange", err_stat, 0);
        ovr = 1'b1;
        #1;
        chk("R9 no status before edge", err_stat, 0);
        tick();
        chk("R9 status after edge", err_stat, 1);
        chk("R9 err_n after edge", err_n, 0);
        ovr = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (!err_stat || err_n) drops++;
        end
        chk("R10 error sticky", drops, 0);
        rst_n = 1'b0; tick();
        chk("R10 cleared by reset status", err_stat, 0);
        chk("R10 cleared by reset err_n", err_n, 1);
        rst_n = 1'b1; tick();
    endtask

    task automatic t_mux();
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 4; v++) begin
                sel_test = s[0];
                mdat     = v[0];
                tdat     = v[1];
                #1;
                chk("R11 input select", filt_din, s ? v[1] : v[0]);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; pwrdn = 1'b0; sync = 1'b0; dec_rst = 1'b0;
        ovr = 1'b0; sel_test = 1'b0; mdat = 1'b0; tdat = 1'b0;
        t_reset();
        t_divide();
        t_sync_mid();
        t_pwrdn_boundary();
        t_decrst();
        t_error();
        t_mux();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule